// File: doc/BRIEF.md
# Double-Rate Write Burst Capture

This block receives the data phase of a memory write. A WRITE command supplies a bank, a starting column and a burst length of four or eight. The block waits a fixed number of clock cycles, the write latency, and then takes two data elements in each clock cycle. The element that arrives with the rising strobe edge goes to one column, and the element that arrives with the falling edge goes to the next column. Each element passes through a byte mask before it is written into a small internal array. The array can be read combinationally so that its contents can be inspected.

In this model the strobe is a half-cycle-shifted copy of the clock. The `dqs_tog` input is high for each clock cycle in which the strobe produces a rising edge and a falling edge. The strobe stays low during the preamble before the first data slot and during the postamble after the last one. A WRITE issued half a burst length after the previous one chains onto it with no gap. A WRITE issued two cycles into an eight-element burst cuts that burst short.

Top module: `ddr_wr_capture`

## Requirements
- R1: After synchronous reset every array word reads zero and `burst_done` is low.
- R2: When `wr_cmd` is sampled high at clock edge P0, the element pair driven for edge P0+WL is written: the rising element goes to the starting column and the falling element to the next column. WL defaults to 3.
- R3: Each later pair is taken on the following edge. A burst of four (`wr_bl8`=0) uses two consecutive edges. A burst of eight (`wr_bl8`=1) uses four.
- R4: Column addresses count upward and wrap inside the block of 4 columns (or 8 columns) that contains the start, aligned to the burst length. For example, start column 5 with a burst of eight visits 5,6,7,0,1,2,3,4.
- R5: Byte lane l is data bits [8l+7:8l]. When its mask bit (`dm_rise[l]` or `dm_fall[l]`) is 1, that byte of the stored word is left unchanged. When the mask bit is 0, the byte is written.
- R6: When `dqs_tog` is low during a data slot, the two elements of that slot are not stored. The preamble or postamble strobe is low at those times.
- R7: Data, masks and strobe activity outside any data slot change nothing.
- R8: A second WRITE sampled 2 edges (for a burst of four) after the first takes its first pair on the edge that follows the first burst's last pair.
- R9: A WRITE sampled 2 edges after a burst-of-eight WRITE cuts that burst after four elements. The old burst's remaining four columns are not written.
- R10: `burst_done` is high for exactly one cycle, in the cycle that follows a burst's last data slot. A truncated burst produces no pulse.
- R11: Writes go only to the bank that `wr_bank` gave with the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe is its half-cycle-shifted copy |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | WRITE command valid |
| wr_bank | input | BANK_W | Target bank |
| wr_col | input | COL_W | Starting column |
| wr_bl8 | input | 1 | 1 = burst of eight, 0 = burst of four |
| dqs_tog | input | 1 | Strobe toggles (rising then falling) in this cycle |
| dq_rise | input | 8*LANES | Element carried by the rising strobe edge |
| dq_fall | input | 8*LANES | Element carried by the falling strobe edge |
| dm_rise | input | LANES | Byte masks for the rising element, 1 = discard |
| dm_fall | input | LANES | Byte masks for the falling element, 1 = discard |
| rd_bank | input | BANK_W | Inspection read bank |
| rd_col | input | COL_W | Inspection read column |
| rd_data | output | 8*LANES | Word stored at the inspection address |
| burst_done | output | 1 | One-cycle pulse after a burst's last slot |

## Verification
The burst engine is driven with the following patterns, and each one separates a different kind of fault:
- An aligned burst of four shows whether the latency count or the rising/falling element order is wrong.
- An unaligned burst of eight shows whether the column address wraps or carries past the aligned block.
- Mixed byte masks on a pre-filled row show whether masking applies per lane and per edge.
- A slot with a silent strobe, and bus activity with no command pending, show whether capture follows the strobe framing.
- Chained and truncating command pairs show whether a new command takes over at the correct beat, whether a cut burst's tail is dropped, and where the done pulses fall.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

    typedef enum logic {
        BURST4 = 1'b0,
        BURST8 = 1'b1
    } burst_e;

    localparam int BEAT_W  = 2;
    localparam int COL_MAX = 16;

    // Column of element ofs inside a burst that starts at start, wrapping in the aligned block
    function automatic logic [COL_MAX-1:0] wrap_col(input logic [COL_MAX-1:0] start,
                                                   input logic [2:0] ofs,
                                                   input burst_e bl);
        logic [COL_MAX-1:0] m;
        logic [COL_MAX-1:0] s;
        m = (bl == BURST8) ? COL_MAX'(7) : COL_MAX'(3);
        s = start + COL_MAX'(ofs);
        return (start & ~m) | (s & m);
    endfunction

    function automatic logic [BEAT_W-1:0] final_beat(input burst_e bl);
        return (bl == BURST8) ? BEAT_W'(3) : BEAT_W'(1);
    endfunction

endpackage

// File: rtl/ddr_wr_cmd_delay.sv
module ddr_wr_cmd_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);
    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     dat_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_vld;
            for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        dat_q[0] <= in_dat;
        for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_dat = dat_q[DEPTH-1];
endmodule

// File: rtl/ddr_wr_burst_seq.sv
module ddr_wr_burst_seq
    import ddr_wr_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BANK_W-1:0] st_bank,
    input  logic [COL_W-1:0]  st_col,
    input  burst_e            st_bl,
    input  logic              dqs_tog,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col_r,
    output logic [COL_W-1:0]  wr_col_f,
    output logic              done
);
    logic              act_q;
    burst_e            bl_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              done_q;

    logic              cur_act;
    burst_e            cur_bl;
    logic [BEAT_W-1:0] cur_beat;
    logic [BANK_W-1:0] cur_bank;
    logic [COL_W-1:0]  cur_col;
    logic              is_last;

    // A freshly arrived command always wins: this gives both chaining and truncation
    always_comb begin
        if (start) begin
            cur_act  = 1'b1;
            cur_bl   = st_bl;
            cur_beat = '0;
            cur_bank = st_bank;
            cur_col  = st_col;
        end else begin
            cur_act  = act_q;
            cur_bl   = bl_q;
            cur_beat = beat_q;
            cur_bank = bank_q;
            cur_col  = col_q;
        end
        is_last = cur_act && (cur_beat == final_beat(cur_bl));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            bl_q   <= BURST4;
            beat_q <= '0;
            bank_q <= '0;
            col_q  <= '0;
            done_q <= 1'b0;
        end else begin
            act_q  <= cur_act && !is_last;
            bl_q   <= cur_bl;
            beat_q <= cur_beat + BEAT_W'(1);
            bank_q <= cur_bank;
            col_q  <= cur_col;
            done_q <= is_last;
        end
    end

    assign wr_en    = cur_act && dqs_tog;
    assign wr_bank  = cur_bank;
    assign wr_col_r = COL_W'(wrap_col(COL_MAX'(cur_col), {cur_beat, 1'b0}, cur_bl));
    assign wr_col_f = COL_W'(wrap_col(COL_MAX'(cur_col), {cur_beat, 1'b1}, cur_bl));
    assign done     = done_q;

    // R3: a running burst never holds a beat index beyond its last slot
    assert_beat_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (beat_q != '0) && (beat_q <= final_beat(bl_q)));

    // R4: the two elements of one slot never land on the same column
    assert_cols_distinct_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_col_r != wr_col_f));

    // R7: with neither a new nor a running burst nothing is written
    assert_idle_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!start && !act_q) |-> !wr_en);

    // R10: every burst spans at least two slots, so done never lasts two cycles
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/ddr_wr_mem.sv
module ddr_wr_mem #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    parameter int LANES  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [BANK_W-1:0]     bank,
    input  logic [COL_W-1:0]      col_r,
    input  logic [COL_W-1:0]      col_f,
    input  logic [8*LANES-1:0]    dat_r,
    input  logic [8*LANES-1:0]    dat_f,
    input  logic [LANES-1:0]      msk_r,
    input  logic [LANES-1:0]      msk_f,
    input  logic [BANK_W-1:0]     rd_bank,
    input  logic [COL_W-1:0]      rd_col,
    output logic [8*LANES-1:0]    rd_data
);
    localparam int AW    = BANK_W + COL_W;
    localparam int WORDS = 1 << AW;
    localparam int DW    = 8 * LANES;

    logic [DW-1:0] mem [WORDS];
    logic [AW-1:0] addr_r;
    logic [AW-1:0] addr_f;

    assign addr_r = {bank, col_r};
    assign addr_f = {bank, col_f};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (!msk_r[l]) mem[addr_r][8*l +: 8] <= dat_r[8*l +: 8];
                if (!msk_f[l]) mem[addr_f][8*l +: 8] <= dat_f[8*l +: 8];
            end
        end
    end

    assign rd_data = mem[{rd_bank, rd_col}];
endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
    import ddr_wr_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    parameter int LANES  = 2,
    parameter int WL     = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_cmd,
    input  logic [BANK_W-1:0]     wr_bank,
    input  logic [COL_W-1:0]      wr_col,
    input  logic                  wr_bl8,
    input  logic                  dqs_tog,
    input  logic [8*LANES-1:0]    dq_rise,
    input  logic [8*LANES-1:0]    dq_fall,
    input  logic [LANES-1:0]      dm_rise,
    input  logic [LANES-1:0]      dm_fall,
    input  logic [BANK_W-1:0]     rd_bank,
    input  logic [COL_W-1:0]      rd_col,
    output logic [8*LANES-1:0]    rd_data,
    output logic                  burst_done
);
    localparam int CMD_W = 1 + BANK_W + COL_W;

    logic              st_vld;
    logic [CMD_W-1:0]  st_dat;
    logic              we;
    logic [BANK_W-1:0] w_bank;
    logic [COL_W-1:0]  w_col_r;
    logic [COL_W-1:0]  w_col_f;

    ddr_wr_cmd_delay #(.W(CMD_W), .DEPTH(WL)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (wr_cmd),
        .in_dat  ({wr_bl8, wr_bank, wr_col}),
        .out_vld (st_vld),
        .out_dat (st_dat)
    );

    ddr_wr_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (st_vld),
        .st_bank  (st_dat[COL_W +: BANK_W]),
        .st_col   (st_dat[COL_W-1:0]),
        .st_bl    (burst_e'(st_dat[CMD_W-1])),
        .dqs_tog  (dqs_tog),
        .wr_en    (we),
        .wr_bank  (w_bank),
        .wr_col_r (w_col_r),
        .wr_col_f (w_col_f),
        .done     (burst_done)
    );

    ddr_wr_mem #(.BANK_W(BANK_W), .COL_W(COL_W), .LANES(LANES)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .bank    (w_bank),
        .col_r   (w_col_r),
        .col_f   (w_col_f),
        .dat_r   (dq_rise),
        .dat_f   (dq_fall),
        .msk_r   (dm_rise),
        .msk_f   (dm_fall),
        .rd_bank (rd_bank),
        .rd_col  (rd_col),
        .rd_data (rd_data)
    );
endmodule

// File: tb/ddr_wr_capture_tb_top.sv
`timescale 1ns/1ps
module ddr_wr_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_cmd = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic [3:0]  wr_col = '0;
    logic        wr_bl8 = 1'b0;
    logic        dqs_tog = 1'b0;
    logic [15:0] dq_rise = '0;
    logic [15:0] dq_fall = '0;
    logic [1:0]  dm_rise = '0;
    logic [1:0]  dm_fall = '0;
    logic [1:0]  rd_bank = '0;
    logic [3:0]  rd_col = '0;
    logic [15:0] rd_data;
    logic        burst_done;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_m [4][16];

    always #10 clk = ~clk;

    ddr_wr_capture dut_i (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_bank(wr_bank), .wr_col(wr_col),
        .wr_bl8(wr_bl8), .dqs_tog(dqs_tog), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dm_rise(dm_rise), .dm_fall(dm_fall), .rd_bank(rd_bank), .rd_col(rd_col),
        .rd_data(rd_data), .burst_done(burst_done)
    );

    task automatic tick(input logic c, input logic [1:0] b, input logic [3:0] col,
                        input logic b8, input logic t, input logic [15:0] dr,
                        input logic [15:0] df, input logic [1:0] mr, input logic [1:0] mf);
        @(negedge clk);
        wr_cmd = c; wr_bank = b; wr_col = col; wr_bl8 = b8;
        dqs_tog = t; dq_rise = dr; dq_fall = df; dm_rise = mr; dm_fall = mf;
    endtask

    task automatic idle();
        tick(1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'h0, 16'h0, 2'b11, 2'b11);
    endtask

    task automatic cmd(input logic [1:0] b, input logic [3:0] col, input logic b8);
        tick(1'b1, b, col, b8, 1'b0, 16'h0, 16'h0, 2'b11, 2'b11);
    endtask

    task automatic beat(input logic [15:0] dr, input logic [15:0] df);
        tick(1'b0, 2'd0, 4'd0, 1'b0, 1'b1, dr, df, 2'b00, 2'b00);
    endtask

    task automatic check_done(input logic e, input string req);
        checks++;
        if (burst_done !== e) begin
            errors++;
            $display("FAIL %s: burst_done actual %0b expected %0b at %0t", req, burst_done, e, $time);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        checks++;
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 16; c++) begin
                rd_bank = 2'(b); rd_col = 4'(c);
                #0.1;
                if (rd_data !== exp_m[b][c] && bad == 0) begin
                    bad = 1;
                    errors++;
                    $display("FAIL %s: bank %0d col %0d actual %h expected %h",
                             req, b, c, rd_data, exp_m[b][c]);
                end
            end
        end
    endtask

    task automatic t_reset();
        check_mem("R1");
        check_done(1'b0, "R1");
    endtask

    task automatic t_aligned_bl4();
        cmd(2'd1, 4'd4, 1'b0);
        idle(); idle();
        beat(16'h1111, 16'h2222);
        beat(16'h3333, 16'h4444);
        idle(); check_done(1'b1, "R10");
        idle(); check_done(1'b0, "R10");
        exp_m[1][4] = 16'h1111; exp_m[1][5] = 16'h2222;
        exp_m[1][6] = 16'h3333; exp_m[1][7] = 16'h4444;
        check_mem("R2 R3 R11");
    endtask

    task automatic t_wrap_bl8();
        int cols[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
        cmd(2'd2, 4'd5, 1'b1);
        idle(); idle();
        for (int k = 0; k < 4; k++) beat(16'h3000 + 16'(2*k), 16'h3000 + 16'(2*k+1));
        idle(); check_done(1'b1, "R10");
        idle();
        for (int k = 0; k < 8; k++) exp_m[2][cols[k]] = 16'h3000 + 16'(k);
        check_mem("R4");
    endtask

    task automatic t_mask();
        cmd(2'd3, 4'd0, 1'b0);
        idle(); idle();
        beat(16'hA5A5, 16'hA5A5);
        beat(16'hA5A5, 16'hA5A5);
        idle(); idle();
        cmd(2'd3, 4'd0, 1'b0);
        idle(); idle();
        tick(1'b0, 2'd0, 4'd0, 1'b0, 1'b1, 16'h1234, 16'h5678, 2'b01, 2'b10);
        tick(1'b0, 2'd0, 4'd0, 1'b0, 1'b1, 16'h9ABC, 16'hDEF0, 2'b11, 2'b00);
        idle(); idle();
        exp_m[3][0] = 16'h12A5; exp_m[3][1] = 16'hA578;
        exp_m[3][2] = 16'hA5A5; exp_m[3][3] = 16'hDEF0;
        check_mem("R5");
    endtask

    task automatic t_strobe_low();
        cmd(2'd0, 4'd8, 1'b0);
        idle(); idle();
        tick(1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'hEEEE, 16'hEEEE, 2'b00, 2'b00);
        beat(16'h5001, 16'h5002);
        idle(); check_done(1'b1, "R10");
        idle();
        exp_m[0][10] = 16'h5001; exp_m[0][11] = 16'h5002;
        check_mem("R6");
    endtask

    task automatic t_idle_bus();
        for (int k = 0; k < 6; k++) beat(16'hFFFF, 16'hFFFF);
        check_done(1'b0, "R7");
        idle();
        check_mem("R7");
    endtask

    task automatic t_seamless();
        cmd(2'd1, 4'd8, 1'b0);
        idle();
        cmd(2'd1, 4'd12, 1'b0);
        beat(16'h6000, 16'h6001);
        beat(16'h6002, 16'h6003);
        beat(16'h6004, 16'h6005);
        check_done(1'b1, "R8 R10");
        beat(16'h6006, 16'h6007);
        check_done(1'b0, "R10");
        idle(); check_done(1'b1, "R8 R10");
        idle();
        for (int k = 0; k < 8; k++) exp_m[1][8+k] = 16'h6000 + 16'(k);
        check_mem("R8");
    endtask

    task automatic t_truncate();
        cmd(2'd2, 4'd8, 1'b1);
        idle();
        cmd(2'd3, 4'd8, 1'b1);
        beat(16'h7000, 16'h7001);
        beat(16'h7002, 16'h7003);
        beat(16'h8000, 16'h8001);
        check_done(1'b0, "R9 R10");
        beat(16'h8002, 16'h8003);
        check_done(1'b0, "R9 R10");
        beat(16'h8004, 16'h8005);
        beat(16'h8006, 16'h8007);
        idle(); check_done(1'b1, "R10");
        idle();
        for (int k = 0; k < 4; k++) exp_m[2][8+k] = 16'h7000 + 16'(k);
        for (int k = 0; k < 8; k++) exp_m[3][8+k] = 16'h8000 + 16'(k);
        check_mem("R9");
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 16; c++) exp_m[b][c] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_aligned_bl4();
        t_wrap_bl8();
        t_mask();
        t_strobe_low();
        t_idle_bus();
        t_seamless();
        t_truncate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule